// File: doc/BRIEF.md
# Doorbell Interrupt Unit

The doorbell unit holds, for each of four CPUs, a 32-bit word of pending doorbells and a 32-bit enable word. Software rings a doorbell with one write to a global trigger register. The written value names a doorbell number and a map of target CPUs, and the unit sets that doorbell in every CPU the map selects. An MSI from a PCIe endpoint is modelled as the same kind of write, with every CPU selected and a doorbell number in the upper half of the word.

Doorbells 0 to 7 are inter-processor interrupts. Doorbells 16 to 31 carry MSI vectors 0 to 15. Each CPU has two request lines. The inter-processor line is raised by any pending and enabled doorbell in the low range, and the MSI line by any pending and enabled doorbell in the high range. These two lines feed interrupt IDs 0 and 1 of the main interrupt controller. A handler reads its pending word. It then writes that word back with the handled bits at 0, which clears those bits and leaves the others pending.

Top module: `db_unit`

## Requirements
- R1: After reset, every pending bit and every enable bit of every CPU is 0, and all request outputs are low.
- R2: A write with `busGlobal`=1 at byte offset 0x4 takes the doorbell number from data bits [7:0] and the CPU target map from bits [11:8], where map bit c selects CPU c. It sets that doorbell's pending bit in each selected CPU and leaves the other CPUs unchanged.
- R3: A trigger whose doorbell number is 8 to 15, or 32 or above, changes no pending bit in any CPU.
- R4: An MSI write of data 0xF00 | (v+16), for vector v from 0 to 15, sets pending bit v+16 in all four CPUs.
- R5: A write with `busGlobal`=0 at offset 0x8 to the CPU chosen by `busCpu` clears each of that CPU's pending bits written as 0. Bits written as 1 keep their value, and no other CPU is affected.
- R6: A write with `busGlobal`=0 at offset 0xC loads the enable word of the CPU chosen by `busCpu` only. An enable bit at 1 enables the doorbell of the same number.
- R7: `ipiReq[c]` is high exactly when CPU c has a doorbell from 0 to 7 that is both pending and enabled.
- R8: `msiReq[c]` is high exactly when CPU c has a doorbell from 16 to 31 that is both pending and enabled. Doorbells 8 to 15 drive neither output.
- R9: With `busGlobal`=0, `busRdata` returns the chosen CPU's pending word at offset 0x8 and its enable word at offset 0xC, in the same cycle. Any other offset, or any global access, reads 0.
- R10: Register and request outputs take their new values at the first clock edge after the write. Writes to offsets other than those named above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for one cycle |
| busGlobal | input | 1 | 1 selects the global space, 0 the per-CPU space |
| busCpu | input | 2 | CPU whose per-CPU registers are accessed |
| busAddr | input | 12 | Byte offset in the selected space |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| ipiReq | output | 4 | Per-CPU inter-processor request (interrupt ID 0) |
| msiReq | output | 4 | Per-CPU MSI request (interrupt ID 1) |

## Verification
A pending bit set in the wrong CPU, or missed, shows up in the next read of that CPU's pending word. Once an enable bit in the matching range is set, the same fault also shows on that CPU's request line one cycle after the trigger. A clear that touches the wrong bits or the wrong CPU shows up in the read-back right after the clearing write. A range-decode fault in the request logic shows as a request line that disagrees with the read-back pending and enable words in that same cycle. The bench checks every CPU after each operation, so any fault is reported at the operation that caused it.

// File: rtl/db_pkg.sv
package db_pkg;
  parameter int CPU_N = 4;
  parameter int DB_N = 32;
  parameter int ADDR_W = 12;
  parameter int NUM_W = 8;
  parameter int IPI_LO = 0;
  parameter int IPI_HI = 7;
  parameter int MSI_LO = 16;
  parameter int MSI_HI = 31;
  parameter logic [ADDR_W-1:0] TRIG_OFS = 12'h004;
  parameter logic [ADDR_W-1:0] PEND_OFS = 12'h008;
  parameter logic [ADDR_W-1:0] ENAB_OFS = 12'h00C;

  localparam int CPU_W = $clog2(CPU_N);
  localparam int IDX_W = $clog2(DB_N);
  localparam int MAP_LSB = NUM_W;
  localparam int TRIG_W = NUM_W + CPU_N;
  localparam logic [DB_N-1:0] IPI_MASK =
    ({DB_N{1'b1}} >> (DB_N - 1 - IPI_HI)) & ({DB_N{1'b1}} << IPI_LO);
  localparam logic [DB_N-1:0] MSI_MASK =
    ({DB_N{1'b1}} >> (DB_N - 1 - MSI_HI)) & ({DB_N{1'b1}} << MSI_LO);

  typedef struct packed {
    logic [CPU_N-1:0] trigHit;
    logic [DB_N-1:0]  trigVec;
    logic [CPU_N-1:0] pendWr;
    logic [CPU_N-1:0] enabWr;
    logic             rdPend;
    logic             rdEnab;
  } strobe_t;
endpackage

// File: rtl/db_ctrl.sv
module db_ctrl
  import db_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busGlobal,
  input  logic [CPU_W-1:0]  busCpu,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [TRIG_W-1:0] trigData,
  output strobe_t           strb
);
  logic              isTrig;
  logic              numOk;
  logic [NUM_W-1:0]  dbNum;
  logic [CPU_N-1:0]  cpuSel;

  assign dbNum = trigData[NUM_W-1:0];
  assign isTrig = busWr && busGlobal && (busAddr == TRIG_OFS);
  assign numOk = ((int'(dbNum) >= IPI_LO) && (int'(dbNum) <= IPI_HI)) ||
                 ((int'(dbNum) >= MSI_LO) && (int'(dbNum) <= MSI_HI));
  assign cpuSel = CPU_N'(1) << busCpu;

  always_comb begin
    strb = '0;
    if (isTrig && numOk) begin
      strb.trigVec = DB_N'(1) << dbNum[IDX_W-1:0];
      strb.trigHit = trigData[MAP_LSB +: CPU_N];
    end
    if (busWr && !busGlobal && (busAddr == PEND_OFS)) strb.pendWr = cpuSel;
    if (busWr && !busGlobal && (busAddr == ENAB_OFS)) strb.enabWr = cpuSel;
    strb.rdPend = !busGlobal && (busAddr == PEND_OFS);
    strb.rdEnab = !busGlobal && (busAddr == ENAB_OFS);
  end

  // A trigger selects at most one doorbell, and never one from the unused gap.
  assert_one_doorbell_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.trigVec));
  assert_gap_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trigVec & ~(IPI_MASK | MSI_MASK)) == '0);
  assert_single_cpu_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.pendWr) && $onehot0(strb.enabWr));
endmodule

// File: rtl/db_datapath.sv
module db_datapath
  import db_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CPU_W-1:0] busCpu,
  input  logic [DB_N-1:0]  busWdata,
  output logic [DB_N-1:0]  busRdata,
  output logic [CPU_N-1:0] ipiReq,
  output logic [CPU_N-1:0] msiReq
);
  logic [CPU_N-1:0][DB_N-1:0] pendQ;
  logic [CPU_N-1:0][DB_N-1:0] enabQ;
  logic [CPU_N-1:0][DB_N-1:0] setVec;

  for (genvar c = 0; c < CPU_N; c++) begin : g_cpu
    logic [DB_N-1:0] keepMask;
    assign setVec[c] = strb.trigHit[c] ? strb.trigVec : '0;
    assign keepMask = strb.pendWr[c] ? busWdata : '1;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[c] <= '0;
        enabQ[c] <= '0;
      end else begin
        // set takes priority over a clear of the same bit
        pendQ[c] <= (pendQ[c] & keepMask) | setVec[c];
        if (strb.enabWr[c]) enabQ[c] <= busWdata;
      end
    end

    assign ipiReq[c] = |(pendQ[c] & enabQ[c] & IPI_MASK);
    assign msiReq[c] = |(pendQ[c] & enabQ[c] & MSI_MASK);

    assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      strb.trigHit[c] |=> ((pendQ[c] & $past(strb.trigVec)) == $past(strb.trigVec)));
    assert_pend_rise_only_by_trig_R3: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> ((pendQ[c] & ~$past(pendQ[c]) & ~$past(setVec[c])) == '0));
    assert_clear_keeps_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
      strb.pendWr[c] |=> ((pendQ[c] & ~$past(busWdata) & ~$past(setVec[c])) == '0));
    assert_enab_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !strb.enabWr[c] |=> $stable(enabQ[c]));
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdPend) busRdata = pendQ[busCpu];
    else if (strb.rdEnab) busRdata = enabQ[busCpu];
  end
endmodule

// File: rtl/db_unit.sv
module db_unit
  import db_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busGlobal,
  input  logic [CPU_W-1:0]  busCpu,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DB_N-1:0]   busWdata,
  output logic [DB_N-1:0]   busRdata,
  output logic [CPU_N-1:0]  ipiReq,
  output logic [CPU_N-1:0]  msiReq
);
  strobe_t strb;

  db_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busGlobal(busGlobal),
    .busCpu(busCpu), .busAddr(busAddr), .trigData(busWdata[TRIG_W-1:0]),
    .strb(strb)
  );

  db_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busCpu(busCpu),
    .busWdata(busWdata), .busRdata(busRdata),
    .ipiReq(ipiReq), .msiReq(msiReq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (ipiReq == '0) && (msiReq == '0));
endmodule

// File: tb/db_unit_tb.sv
module db_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic busGlobal = 1'b0;
  logic [1:0] busCpu = '0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0] ipiReq, msiReq;

  int nChk = 0;
  int nErr = 0;
  logic [31:0] mPend [NC];
  logic [31:0] mEnab [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  db_unit dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busGlobal(busGlobal),
    .busCpu(busCpu), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .ipiReq(ipiReq), .msiReq(msiReq)
  );

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic g, input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busGlobal = g; busCpu = 2'(cpu); busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic g, input int cpu, input logic [11:0] a, output logic [31:0] d);
    busGlobal = g; busCpu = 2'(cpu); busAddr = a;
    #1;
    d = busRdata;
  endtask

  // bench model of one trigger write
  task automatic trig(input logic [31:0] d);
    int n;
    n = int'(d[7:0]);
    wr(1'b1, 0, 12'h004, d);
    if (n <= 7 || (n >= 16 && n <= 31))
      for (int c = 0; c < NC; c++) if (d[8+c]) mPend[c][n] = 1'b1;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      rd(1'b0, c, 12'h008, v);
      cmp(req, $sformatf("pend cpu%0d", c), v, mPend[c]);
      rd(1'b0, c, 12'h00C, v);
      cmp(req, $sformatf("enab cpu%0d", c), v, mEnab[c]);
    end
    // R7 R8: request lines from the model words
    for (int c = 0; c < NC; c++) begin
      cmp("R7", $sformatf("ipiReq cpu%0d", c), 32'(ipiReq[c]), 32'(|(mPend[c] & mEnab[c] & 32'h0000_00FF)));
      cmp("R8", $sformatf("msiReq cpu%0d", c), 32'(msiReq[c]), 32'(|(mPend[c] & mEnab[c] & 32'hFFFF_0000)));
    end
  endtask

  task automatic clearAll();
    for (int c = 0; c < NC; c++) begin
      wr(1'b0, c, 12'h008, 32'h0);
      mPend[c] = '0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nErr++; nChk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] seed;
    for (int c = 0; c < NC; c++) begin mPend[c] = '0; mEnab[c] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    cmp("R1", "ipiReq", 32'(ipiReq), 0);
    cmp("R1", "msiReq", 32'(msiReq), 0);

    // R6: enable words per CPU, only the selected one changes
    begin
      logic [31:0] pat [NC];
      pat[0] = 32'hFFFF_00FF; pat[1] = 32'h0000_00FF; pat[2] = 32'hFFFF_0000; pat[3] = 32'h0000_FF00;
      for (int c = 0; c < NC; c++) begin
        wr(1'b0, c, 12'h00C, pat[c]);
        mEnab[c] = pat[c];
        checkAll("R6");
      end
    end

    // R2 R3 R10: sweep doorbell numbers and target maps
    for (int n = 0; n < 40; n++) begin
      for (int m = 0; m < 16; m++) begin
        trig({20'h0, 4'(m), 8'(n)});
        checkAll((n <= 7 || (n >= 16 && n <= 31)) ? "R2" : "R3");
        clearAll();
      end
    end
    // R3: large number with upper bit set
    trig(32'h0000_0F85);
    checkAll("R3");

    // R4: MSI data pattern for each vector accumulates
    for (int vct = 0; vct < 16; vct++) begin
      trig(32'h0000_0F00 | 32'(vct + 16));
      checkAll("R4");
    end
    clearAll();
    checkAll("R5");

    // R5: partial clear keeps bits written as 1, one CPU only
    seed = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 6; j++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        trig({20'h0, seed[11:8], 3'b000, seed[20:16]});
      end
      seed = seed * 32'd1664525 + 32'd1013904223;
      wr(1'b0, int'(seed[31:30]), 12'h008, seed);
      mPend[seed[31:30]] = mPend[seed[31:30]] & seed;
      checkAll("R5");
    end

    // R7 R8: vary enable words against current pending state
    for (int k = 0; k < 24; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      wr(1'b0, k % NC, 12'h00C, seed ^ {seed[15:0], seed[31:16]});
      mEnab[k % NC] = seed ^ {seed[15:0], seed[31:16]};
      checkAll((k % 2) ? "R7" : "R8");
    end

    // R9 R10: other offsets read 0 and writes to them change nothing
    rd(1'b0, 1, 12'h010, v); cmp("R9", "unmapped read", v, 0);
    rd(1'b1, 1, 12'h008, v); cmp("R9", "global read", v, 0);
    wr(1'b0, 2, 12'h004, 32'h0000_0F01);
    wr(1'b1, 2, 12'h008, 32'h0);
    wr(1'b1, 2, 12'h00C, 32'h0);
    wr(1'b0, 2, 12'h020, 32'h0);
    checkAll("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule